// File: doc/BRIEF.md
# Serial Frequency Setting Register

This block is a write-only serial slave that holds a 16-bit oscillator setting word. A host drives three wires: an active-low select, a serial clock and a data line. The block samples all three with a faster system clock, shifts data in on rising serial-clock edges while select is low, and commits each completed byte straight into the setting register. The first byte of a frame fills the upper half of the word and the second byte fills the lower half. Because each byte is committed as soon as it is complete, a host may end a frame after eight clocks to change only the upper half.

The word is presented as three parallel fields: a 4-bit octave divider code, a 10-bit fine frequency code and a 2-bit output configuration code. A one-cycle update pulse in the system clock domain marks every committed byte, so downstream logic can react to a new setting without comparing words.

Top module: `fcfg_serial_reg`

## Requirements
- R1: After reset, oct_o, dac_o and cnf_o are all zero and upd_o is low.
- R2: A 16-bit frame is taken most significant bit first; the received word W drives oct_o = W[15:12], dac_o = W[11:2], cnf_o = W[1:0].
- R3: A frame that ends after exactly eight serial clocks rewrites only W[15:8]; W[7:0] keeps its previous value.
- R4: When select rises with fewer than eight edges received since the last commit, those bits are dropped and the word is unchanged.
- R5: Each frame starts at W[15], even when the frame before it ended on a partial byte.
- R6: Serial clock edges and data while select is high have no effect on the word and produce no update pulse.
- R7: upd_o is high for exactly one system clock per committed byte: two pulses for a 16-bit frame, one for an 8-bit frame, none for a frame of fewer than eight clocks.
- R8: The output fields change only in a cycle where upd_o is high.
- R9: In a frame longer than 16 clocks, the byte index wraps, so the third byte is written to W[15:8] again and the fourth to W[7:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than four times the serial clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sel_n | input | 1 | Serial select, active low; frames a transfer |
| sck | input | 1 | Serial clock; data taken on its rising edge |
| sdi | input | 1 | Serial data, most significant bit first |
| oct_o | output | 4 | Octave divider code, W[15:12] |
| dac_o | output | 10 | Fine frequency code, W[11:2] |
| cnf_o | output | 2 | Output configuration code, W[1:0] |
| upd_o | output | 1 | One-cycle pulse when a byte has been committed |

## Verification
The hardest state to reach is a frame that stops in the middle of a byte and is followed by another frame: the discarded bits sit in the shift register and the counter must be back at zero, so a misaligned next frame would only show as a shifted word. The stimulus table places a 5-clock and a 12-clock frame directly before full frames, and a 24-clock frame exercises the byte index wrap, with known distinctive words so any misalignment changes the observed fields. Serial clock toggling with select high is driven separately and the update pulse count is checked to stay at zero.

// File: rtl/fcfg_pkg.sv
`timescale 1ns/1ps
package fcfg_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int OCT_W  = 4;
    localparam int DAC_W  = 10;
    localparam int CNF_W  = 2;

    typedef struct packed {
        logic [OCT_W-1:0] oct;
        logic [DAC_W-1:0] dac;
        logic [CNF_W-1:0] cnf;
    } fcfg_word_t;
endpackage

// File: rtl/fcfg_sync.sv
`timescale 1ns/1ps
module fcfg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fcfg_shifter.sv
`timescale 1ns/1ps
module fcfg_shifter #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2,
    localparam int CNT_W = $clog2(BYTE_W),
    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sck,
    input  logic              sdi,
    output logic              commit_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic [IDX_W-1:0]  idx_o
);
    typedef struct packed {
        logic              sck_prev;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] shreg;
        logic              commit;
        logic [BYTE_W-1:0] byte_out;
        logic [IDX_W-1:0]  idx_out;
    } sh_state_t;

    sh_state_t st_d, st_q;
    logic      rise;

    always_comb begin
        st_d          = st_q;
        st_d.sck_prev = sck;
        st_d.commit   = 1'b0;
        rise          = sck && !st_q.sck_prev && !sel_n;
        if (sel_n) begin
            st_d.cnt   = '0;
            st_d.idx   = '0;
            st_d.shreg = '0;
        end else if (rise) begin
            st_d.shreg = {st_q.shreg[BYTE_W-2:0], sdi};
            if (st_q.cnt == CNT_W'(BYTE_W - 1)) begin
                st_d.cnt      = '0;
                st_d.commit   = 1'b1;
                st_d.byte_out = {st_q.shreg[BYTE_W-2:0], sdi};
                st_d.idx_out  = st_q.idx;
                st_d.idx      = (st_q.idx == IDX_W'(NBYTES - 1)) ? '0 : st_q.idx + 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit_o = st_q.commit;
    assign byte_o   = st_q.byte_out;
    assign idx_o    = st_q.idx_out;

    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (st_q.cnt == '0 && st_q.idx == '0));

    // R6
    idle_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !commit_o);

    // R7
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);
endmodule

// File: rtl/fcfg_serial_reg.sv
`timescale 1ns/1ps
module fcfg_serial_reg
    import fcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    localparam int NBYTES = WORD_W / BYTE_W,
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             sck,
    input  logic             sdi,
    output logic [OCT_W-1:0] oct_o,
    output logic [DAC_W-1:0] dac_o,
    output logic [CNF_W-1:0] cnf_o,
    output logic             upd_o
);
    logic              sel_s, sck_s, sdi_s;
    logic              commit;
    logic [BYTE_W-1:0] cbyte;
    logic [IDX_W-1:0]  cidx;

    fcfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
        .clk(clk), .rst_n(rst_n), .d(sel_n), .q(sel_s));
    fcfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .d(sck), .q(sck_s));
    fcfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
        .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s));

    fcfg_shifter #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_shift (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_s), .sck(sck_s), .sdi(sdi_s),
        .commit_o(commit), .byte_o(cbyte), .idx_o(cidx));

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              upd;
    } reg_state_t;

    reg_state_t rs_d, rs_q;
    fcfg_word_t fields;

    always_comb begin
        rs_d     = rs_q;
        rs_d.upd = commit;
        for (int b = 0; b < NBYTES; b++) begin
            if (commit && cidx == IDX_W'(b))
                rs_d.word[WORD_W-1-b*BYTE_W -: BYTE_W] = cbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign fields = fcfg_word_t'(rs_q.word);
    assign oct_o  = fields.oct;
    assign dac_o  = fields.dac;
    assign cnf_o  = fields.cnf;
    assign upd_o  = rs_q.upd;

    // R8
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> $stable({oct_o, dac_o, cnf_o}));

    // R7
    upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

    // R6
    idle_no_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s && !commit) |=> !upd_o);
endmodule

// File: tb/fcfg_serial_reg_tb.sv
`timescale 1ns/1ps
module fcfg_serial_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic [3:0] oct_o;
    logic [9:0] dac_o;
    logic [1:0] cnf_o;
    logic       upd_o;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int bad_chg = 0;
    logic [15:0] prev_word = '0;

    always #2.5 clk = ~clk;

    fcfg_serial_reg u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdi(sdi),
        .oct_o(oct_o), .dac_o(dac_o), .cnf_o(cnf_o), .upd_o(upd_o));

    function automatic logic [15:0] word_now();
        return {oct_o, dac_o, cnf_o};
    endfunction

    always @(posedge clk) begin
        if (upd_o) pulses++;
        if (rst_n && !upd_o && word_now() != prev_word) bad_chg++;
        prev_word <= word_now();
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input int nbits, input logic [23:0] data);
        sel_n = 1'b0;
        wait_clk(10);
        for (int i = 0; i < nbits; i++) begin
            sdi = data[23-i];
            wait_clk(10);
            sck = 1'b1;
            wait_clk(10);
            sck = 1'b0;
        end
        wait_clk(10);
        sel_n = 1'b1;
        wait_clk(20);
    endtask

    // {nbits, data left-aligned in 24 bits, expected word, expected pulses}
    localparam int NV = 8;
    localparam logic [55:0] VEC [0:NV-1] = '{
        {8'd16, 24'hCB0C00, 16'hCB0C, 8'd2},  // R2 oct 12, dac 707
        {8'd16, 24'h123400, 16'h1234, 8'd2},  // R2
        {8'd8,  24'hA50000, 16'hA534, 8'd1},  // R3 upper byte only
        {8'd5,  24'hF80000, 16'hA534, 8'd0},  // R4 partial dropped
        {8'd16, 24'h0FF100, 16'h0FF1, 8'd2},  // R5 realigned after partial
        {8'd12, 24'h5AB000, 16'h5AF1, 8'd1},  // R4 trailing nibble dropped
        {8'd24, 24'h334477, 16'h7744, 8'd3},  // R9 index wrap
        {8'd16, 24'hFFFF00, 16'hFFFF, 8'd2}   // R2 all ones
    };

    initial begin
        wait_clk(5);
        // R1 reset state
        check("R1 word", 32'(word_now()), 32'h0);
        check("R1 upd", 32'(upd_o), 32'h0);
        rst_n = 1'b1;
        wait_clk(5);
        check("R1 word after release", 32'(word_now()), 32'h0);

        for (int v = 0; v < NV; v++) begin
            int p0;
            p0 = pulses;
            send_frame(int'(VEC[v][55:48]), VEC[v][47:24]);
            check($sformatf("R2/R3/R4/R5/R9 word vec %0d", v), 32'(word_now()), 32'(VEC[v][23:8]));
            check($sformatf("R7 pulses vec %0d", v), 32'(pulses - p0), 32'(VEC[v][7:0]));
        end

        // R2 field split of last word 0xFFFF then a distinctive word
        begin
            int p0;
            p0 = pulses;
            send_frame(16, 24'hB2_D7_00);
            check("R2 oct", 32'(oct_o), 32'hB);
            check("R2 dac", 32'(dac_o), 32'h0B5);
            check("R2 cnf", 32'(cnf_o), 32'h3);
            check("R7 pulses", 32'(pulses - p0), 32'd2);
        end

        // R6 clocks with select high are ignored
        begin
            int p0;
            p0 = pulses;
            for (int i = 0; i < 20; i++) begin
                sdi = ~sdi;
                wait_clk(10);
                sck = 1'b1;
                wait_clk(10);
                sck = 1'b0;
            end
            wait_clk(20);
            check("R6 word", 32'(word_now()), 32'hB2D7);
            check("R6 pulses", 32'(pulses - p0), 32'd0);
        end

        // R5 frame after idle toggling starts at D15
        send_frame(16, 24'h8001_00);
        check("R5 word", 32'(word_now()), 32'h8001);

        // R8 fields never changed without the update pulse
        check("R8 changes without upd", 32'(bad_chg), 32'd0);

        // R1 reset in mid-run
        rst_n = 1'b0;
        wait_clk(3);
        check("R1 word on reset", 32'(word_now()), 32'h0);
        check("R1 upd on reset", 32'(upd_o), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule